// File: doc/BRIEF.md
# Two-Stage Compare Watchdog

This block is a watchdog that escalates in two steps. It does not count down locally. It holds a 64-bit deadline and compares it with a free-running system counter that enters the block as an input. When the deadline passes for the first time, a warning flag is set, a level interrupt rises, and the deadline moves one programmed period further on. When the deadline passes again with no service, a final flag is set and the final output rises. That output is meant to feed a reset or high-priority handler outside the block.

Software reaches the block through a 32-bit register port with two 4 KiB windows. A select input chooses between the service window and the configuration window. Servicing the watchdog takes a single write to the service window, so the part of the software that proves it is alive never touches the configuration registers. The configuration window holds the enable and the two status flags, the period, the two halves of the deadline, and an identification word. The service window also carries the identification word.

Top module: `stage_watchdog`

## Requirements
- R1: After synchronous reset, enable, both status flags, the period and the deadline all read as zero, and both `warn_irq` and `final_out` are low.
- R2: Any write to service-window offset 0x000 sets the deadline to counter + period and clears both status flags. The written data has no effect. A read of that offset returns zero.
- R3: In the configuration-window register at offset 0x000, bit 0 is enable, bit 1 is the warning flag and bit 2 is the final flag. Bits 1 and 2 cannot be written. Writing zero disables the watchdog.
- R4: The period is at configuration offset 0x008. Writing it also sets the deadline to counter + new period and clears both flags.
- R5: The deadline can be read and written as two halves: bits 31:0 at configuration offset 0x010 and bits 63:32 at 0x014.
- R6: A write that moves enable from 0 to 1 sets the deadline to counter + period.
- R7: While enabled with the warning flag clear, a clock edge at which counter >= deadline sets the warning flag and moves the deadline to counter + period. At counter = deadline - 1 nothing happens.
- R8: While enabled with the warning flag set, a clock edge at which counter >= deadline sets the final flag.
- R9: Both flags stay set until a service write, a period write or reset. `warn_irq` equals warning flag AND enable, and `final_out` equals final flag AND enable. Both outputs are registered and change at the same edge as the flags.
- R10: Offset 0xFCC in either window reads the `IDENT` parameter. Other offsets read as zero, and writes to them change nothing.
- R11: With enable low, no expiry takes place. When a register write lands on the same edge as an expiry, the write takes effect and the expiry is skipped for that edge.
- R12: A read strobe at one edge gives `bus_rvalid` high and the read data one cycle later. The data shows the register state from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_count | input | 64 | Free-running system counter |
| bus_ctl_win | input | 1 | Window select: 0 service, 1 configuration |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid |
| warn_irq | output | 1 | First-stage warning level |
| final_out | output | 1 | Second-stage final level |

## Verification
The counter input is driven directly, so each deadline boundary can be placed exactly:
- Setting the counter one below the deadline and then equal to it separates `>=` from `>`.
- Two expiries in a row show the deadline reload and the step from warning to final.
- A service write that lands on the same edge as an expiry separates write priority from expiry priority.
- Service writes with non-zero data, attempts to set the status bits, and accesses to unmapped offsets show that those inputs leave the state alone.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned REG_W = 32;

  localparam int unsigned OFS_KICK   = 'h000;
  localparam int unsigned OFS_CTL    = 'h000;
  localparam int unsigned OFS_PERIOD = 'h008;
  localparam int unsigned OFS_CMP_LO = 'h010;
  localparam int unsigned OFS_CMP_HI = 'h014;
  localparam int unsigned OFS_IDENT  = 'hFCC;

  typedef struct packed {
    logic kick;
    logic ctl;
    logic period;
    logic cmp_lo;
    logic cmp_hi;
  } wr_strobe_t;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_CTL,
    RD_PERIOD,
    RD_CMP_LO,
    RD_CMP_HI,
    RD_IDENT
  } rd_src_t;
endpackage

// File: rtl/wdt_decode.sv
module wdt_decode
  import wdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              win_ctl,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  output wr_strobe_t        stb,
  output rd_src_t           src
);
  // Service window (win_ctl = 0) and configuration window (win_ctl = 1)
  // are decoded on their own; only the select picks between them.
  always_comb begin
    stb = '0;
    src = RD_ZERO;
    if (win_ctl) begin
      if (addr == ADDR_W'(OFS_CTL)) begin
        stb.ctl = wr;
        src     = RD_CTL;
      end else if (addr == ADDR_W'(OFS_PERIOD)) begin
        stb.period = wr;
        src        = RD_PERIOD;
      end else if (addr == ADDR_W'(OFS_CMP_LO)) begin
        stb.cmp_lo = wr;
        src        = RD_CMP_LO;
      end else if (addr == ADDR_W'(OFS_CMP_HI)) begin
        stb.cmp_hi = wr;
        src        = RD_CMP_HI;
      end else if (addr == ADDR_W'(OFS_IDENT)) begin
        src = RD_IDENT;
      end
    end else begin
      if (addr == ADDR_W'(OFS_KICK)) begin
        stb.kick = wr;
        src      = RD_ZERO;
      end else if (addr == ADDR_W'(OFS_IDENT)) begin
        src = RD_IDENT;
      end
    end
    if (!rd) src = RD_ZERO;
  end
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned OFF_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] count,
  input  wr_strobe_t       stb,
  input  logic [REG_W-1:0] wdata,
  output logic             en,
  output logic [1:0]       ws,
  output logic [OFF_W-1:0] period,
  output logic [CNT_W-1:0] cmp,
  output logic             warn,
  output logic             fin
);
  localparam int unsigned HI_W = CNT_W - REG_W;

  logic             en_n;
  logic [1:0]       ws_n;
  logic [OFF_W-1:0] period_n;
  logic [CNT_W-1:0] cmp_n;
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] reload_new;
  logic             bus_hit;
  logic             expired;

  assign reload     = count + CNT_W'(period);
  assign reload_new = count + CNT_W'(wdata[OFF_W-1:0]);
  assign bus_hit    = stb.kick | stb.ctl | stb.period | stb.cmp_lo | stb.cmp_hi;
  assign expired    = en && (count >= cmp);

  always_comb begin
    en_n     = en;
    ws_n     = ws;
    period_n = period;
    cmp_n    = cmp;
    if (stb.kick) begin
      cmp_n = reload;
      ws_n  = 2'b00;
    end
    if (stb.period) begin
      period_n = wdata[OFF_W-1:0];
      cmp_n    = reload_new;
      ws_n     = 2'b00;
    end
    if (stb.ctl) begin
      en_n = wdata[0];
      if (wdata[0] && !en) cmp_n = reload;
    end
    if (stb.cmp_lo) cmp_n[REG_W-1:0]     = wdata;
    if (stb.cmp_hi) cmp_n[CNT_W-1:REG_W] = wdata[HI_W-1:0];
    // Bus writes win over an expiry on the same edge.
    if (!bus_hit && expired) begin
      if (!ws[0]) begin
        ws_n[0] = 1'b1;
        cmp_n   = reload;
      end else begin
        ws_n[1] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en     <= 1'b0;
      ws     <= 2'b00;
      period <= '0;
      cmp    <= '0;
      warn   <= 1'b0;
      fin    <= 1'b0;
    end else begin
      en     <= en_n;
      ws     <= ws_n;
      period <= period_n;
      cmp    <= cmp_n;
      warn   <= ws_n[0] & en_n;
      fin    <= ws_n[1] & en_n;
    end
  end
endmodule

// File: rtl/wdt_rdmux.sv
module wdt_rdmux
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned OFF_W = 32,
  parameter logic [REG_W-1:0] IDENT = 32'h0001_A5D3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd,
  input  rd_src_t          src,
  input  logic             en,
  input  logic [1:0]       ws,
  input  logic [OFF_W-1:0] period,
  input  logic [CNT_W-1:0] cmp,
  output logic [REG_W-1:0] rdata,
  output logic             rvalid
);
  localparam int unsigned HI_W = CNT_W - REG_W;

  logic [REG_W-1:0] sel;

  always_comb begin
    unique case (src)
      RD_CTL:    sel = {{(REG_W-3){1'b0}}, ws[1], ws[0], en};
      RD_PERIOD: sel = REG_W'(period);
      RD_CMP_LO: sel = cmp[REG_W-1:0];
      RD_CMP_HI: sel = REG_W'(cmp[CNT_W-1:CNT_W-HI_W]);
      RD_IDENT:  sel = IDENT;
      default:   sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd;
      rdata  <= rd ? sel : '0;
    end
  end
endmodule

// File: rtl/stage_watchdog.sv
module stage_watchdog
  import wdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned OFF_W  = 32,
  parameter logic [31:0] IDENT  = 32'h0001_A5D3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  sys_count,
  input  logic              bus_ctl_win,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic              warn_irq,
  output logic              final_out
);
  wr_strobe_t       stb;
  rd_src_t          src;
  logic             en;
  logic [1:0]       ws;
  logic [OFF_W-1:0] period;
  logic [CNT_W-1:0] cmp;

  wdt_decode #(.ADDR_W(ADDR_W)) u_dec (
    .win_ctl (bus_ctl_win),
    .wr      (bus_wr),
    .rd      (bus_rd),
    .addr    (bus_addr),
    .stb     (stb),
    .src     (src)
  );

  wdt_core #(.CNT_W(CNT_W), .OFF_W(OFF_W)) u_core (
    .clk    (clk),
    .rst    (rst),
    .count  (sys_count),
    .stb    (stb),
    .wdata  (bus_wdata),
    .en     (en),
    .ws     (ws),
    .period (period),
    .cmp    (cmp),
    .warn   (warn_irq),
    .fin    (final_out)
  );

  wdt_rdmux #(.CNT_W(CNT_W), .OFF_W(OFF_W), .IDENT(IDENT)) u_rd (
    .clk    (clk),
    .rst    (rst),
    .rd     (bus_rd),
    .src    (src),
    .en     (en),
    .ws     (ws),
    .period (period),
    .cmp    (cmp),
    .rdata  (bus_rdata),
    .rvalid (bus_rvalid)
  );
endmodule

// File: rtl/stage_watchdog_chk.sv
module stage_watchdog_chk #(
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_ctl_win,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              bus_rvalid,
  input logic              warn_irq,
  input logic              final_out
);
  logic kick_wr;
  logic ctl_wr;
  assign kick_wr = bus_wr && !bus_ctl_win && (bus_addr == '0);
  assign ctl_wr  = bus_wr && bus_ctl_win && (bus_addr == '0);

  a_r2_kick_clears: assert property (@(posedge clk) disable iff (rst)
    kick_wr |=> (!warn_irq && !final_out));

  a_r3_zero_disables: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && !bus_wdata[0]) |=> (!warn_irq && !final_out));

  a_r8_final_needs_warn: assert property (@(posedge clk) disable iff (rst)
    final_out |-> warn_irq);

  a_r9_warn_sticky: assert property (@(posedge clk) disable iff (rst)
    (warn_irq && !bus_wr) |=> warn_irq);

  a_r12_read_valid: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);

  a_r12_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !bus_rvalid);
endmodule

bind stage_watchdog stage_watchdog_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_ctl_win (bus_ctl_win),
  .bus_wr      (bus_wr),
  .bus_rd      (bus_rd),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_rvalid  (bus_rvalid),
  .warn_irq    (warn_irq),
  .final_out   (final_out)
);

// File: tb/sim_stage_watchdog.sv
module sim_stage_watchdog;
  localparam logic [31:0] ID = 32'h0001_A5D3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] sys_count = '0;
  logic        bus_ctl_win = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        warn_irq;
  logic        final_out;

  int checks = 0;
  int failures = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  stage_watchdog #(.IDENT(ID)) u0 (
    .clk(clk), .rst(rst), .sys_count(sys_count),
    .bus_ctl_win(bus_ctl_win), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .warn_irq(warn_irq), .final_out(final_out)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops one expected item per returned read.
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        check("R12 unexpected rvalid", 1, 0);
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic wr(input logic win, input logic [11:0] a, input logic [31:0] d);
    bus_ctl_win = win; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic win, input logic [11:0] a, input logic [31:0] e, input string req);
    bus_ctl_win = win; bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(req);
    @(negedge clk);
    bus_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic outs(input logic w, input logic f, input string req);
    check({req, " warn"}, warn_irq, w);
    check({req, " final"}, final_out, f);
  endtask

  task automatic tick(input logic [63:0] c);
    sys_count = c;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog timeout actual=running expected=done");
    failures++;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    outs(0, 0, "R1");
    rd(1, 12'h000, 0, "R1 ctl");
    rd(1, 12'h008, 0, "R1 period");
    rd(1, 12'h010, 0, "R1 cmp lo");
    rd(1, 12'h014, 0, "R1 cmp hi");
    // R10 identification and unmapped offsets
    rd(0, 12'hFCC, ID, "R10 ident service");
    rd(1, 12'hFCC, ID, "R10 ident config");
    wr(1, 12'h020, 32'hFFFF_FFFF);
    rd(1, 12'h020, 0, "R10 unmapped read");
    rd(1, 12'h008, 0, "R10 unmapped write ignored");
    // R4 period write loads deadline
    tick(1000);
    wr(1, 12'h008, 100);
    rd(1, 12'h008, 100, "R4 period");
    rd(1, 12'h010, 1100, "R4 deadline");
    // R5 halves
    wr(1, 12'h014, 5);
    wr(1, 12'h010, 7);
    rd(1, 12'h010, 7, "R5 lo");
    rd(1, 12'h014, 5, "R5 hi");
    // R6 enable rise with status bits written (R3 ignore)
    tick(2000);
    wr(1, 12'h000, 32'h7);
    rd(1, 12'h000, 1, "R3 status bits not writable");
    rd(1, 12'h010, 2100, "R6 deadline on enable");
    rd(1, 12'h014, 0, "R6 deadline hi");
    // R7 boundary and first expiry
    tick(2099);
    outs(0, 0, "R7 one below");
    tick(2100);
    outs(1, 0, "R7 first expiry");
    rd(1, 12'h010, 2200, "R7 reload");
    rd(1, 12'h000, 3, "R7 status");
    // R8 second expiry
    tick(2199);
    outs(1, 0, "R8 one below");
    tick(2200);
    outs(1, 1, "R8 second expiry");
    rd(1, 12'h000, 7, "R8 status");
    tick(2500);
    outs(1, 1, "R9 sticky");
    // R2 service write with junk data
    tick(3000);
    wr(0, 12'h000, 32'hDEAD_BEEF);
    outs(0, 0, "R2 service clears");
    rd(1, 12'h010, 3100, "R2 deadline");
    rd(1, 12'h008, 100, "R2 data ignored");
    rd(0, 12'h000, 0, "R2 service read zero");
    // R3/R11 disable
    wr(1, 12'h000, 0);
    tick(10000);
    tick(10001);
    outs(0, 0, "R11 disabled no expiry");
    rd(1, 12'h000, 0, "R3 disabled");
    // R11 write priority on same edge
    tick(4000);
    wr(1, 12'h000, 1);
    sys_count = 4100;
    wr(0, 12'h000, 0);
    outs(0, 0, "R11 write wins");
    rd(1, 12'h010, 4200, "R11 deadline from service");
    // R4 period write clears status
    tick(4200);
    outs(1, 0, "R4 setup expiry");
    sys_count = 4260;
    wr(1, 12'h008, 50);
    outs(0, 0, "R4 period clears");
    rd(1, 12'h000, 1, "R4 status");
    rd(1, 12'h010, 4310, "R4 new deadline");
    // R9 outputs gated by enable
    tick(4310);
    outs(1, 0, "R9 warn set");
    wr(1, 12'h000, 0);
    outs(0, 0, "R9 gated by enable");
    rd(1, 12'h000, 2, "R9 flag kept");
    repeat (2) @(negedge clk);
    check("R12 queue drained", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule